// File: doc/BRIEF.md
# Split Indirect-Transfer Word Buffer

A single local RAM of `DEPTH` words, `WIDTH` bits each, is shared by two independent FIFOs. The low addresses form the inbound region, which holds data arriving from the flash side until the host collects it. The high addresses form the outbound region, which holds host data waiting for the flash side. A partition value sets how many words the inbound region owns, and the outbound region takes every word above it. The value can be reloaded at run time, but only while both regions are drained.

The inbound region presents its oldest word ahead of time through one extra output register. Its usable capacity is therefore the partition value plus one. The outbound region answers each pop one cycle later with an acknowledge. Each region reports its fill level in words. Each region also drives a watermark flag: the inbound flag marks a fill above a byte threshold, and the outbound flag marks a fill below one. A push into a full inbound region is dropped and reported by a one-cycle pulse.

Top module: `xfer_split_buf`

## Requirements
- R1: After a synchronous reset, both fill levels are 0, `rd_pop_valid`, `wr_pop_ack`, `rd_full_hit` and the inbound watermark flag are 0, and the partition is `DEF_PART` (64) words.
- R2: Words pushed into the inbound region come out of `rd_pop_data` in push order. `rd_level` counts every stored word, the output register included, and it rises in the cycle after each accepted push.
- R3: `rd_pop_valid` is high whenever `rd_pop_data` holds the oldest inbound word. A pop while `rd_pop_valid` is low is a not-ready case: it removes nothing and leaves `rd_level` unchanged.
- R4: The inbound region accepts at most the partition value plus one words.
- R5: A push into a full inbound region is dropped, the stored data is unchanged, and `rd_full_hit` is high for exactly the one cycle after that push.
- R6: Each region wraps its pointers inside its own address range. The inbound range ends at the partition value, and the outbound range starts there. Data order holds across any number of wraps.
- R7: Words pushed into the outbound region come out in push order. A pop accepted in one cycle raises `wr_pop_ack` in the next cycle, with the word on `wr_pop_data`. `wr_level` counts words.
- R8: The outbound region accepts at most `DEPTH` minus the partition value words, and pushes beyond that are dropped.
- R9: A pop from an empty outbound region gives no acknowledge and leaves `wr_level` at 0.
- R10: `part_val` (a count of inbound words, 0 to `DEPTH`) is loaded on `part_load` only when both regions are empty and neither region is pushed in that cycle. Any other load request is ignored.
- R11: The inbound watermark flag is high exactly when 4×`rd_level` bytes exceeds `rd_wmark`, evaluated one cycle late. A threshold of 0 holds the flag low.
- R12: The outbound watermark flag is high exactly when 4×`wr_level` bytes is below `wr_wmark`, evaluated one cycle late. An all-ones threshold holds the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| part_load | input | 1 | Request to load a new partition |
| part_val | input | AW+1 | Number of inbound words requested |
| rd_push | input | 1 | Push one word into the inbound region |
| rd_push_data | input | WIDTH | Word to push inbound |
| rd_pop | input | 1 | Consume the presented inbound word |
| rd_pop_data | output | WIDTH | Oldest inbound word |
| rd_pop_valid | output | 1 | `rd_pop_data` holds a word |
| rd_level | output | AW+1 | Inbound fill, in words |
| rd_full_hit | output | 1 | Pulse: an inbound push was dropped |
| rd_wmark | input | AW+3 | Inbound threshold, in bytes |
| rd_wm_flag | output | 1 | Inbound fill above threshold |
| wr_push | input | 1 | Push one word into the outbound region |
| wr_push_data | input | WIDTH | Word to push outbound |
| wr_pop | input | 1 | Request the oldest outbound word |
| wr_pop_data | output | WIDTH | Word returned for the previous pop |
| wr_pop_ack | output | 1 | `wr_pop_data` answers last cycle's pop |
| wr_level | output | AW+1 | Outbound fill, in words |
| wr_wmark | input | AW+3 | Outbound threshold, in bytes |
| wr_wm_flag | output | 1 | Outbound fill below threshold |

## Verification
The properties assume that the thresholds change only while their region is idle, so a flag never lags behind a threshold change by more than one cycle. They also assume that partition loads come with drained regions, the only state in which a change can be seen. The stimulus follows both rules: it moves a threshold only between bursts and waits two cycles before sampling a flag. It requests every partition load with both regions empty, except the one load that is meant to be refused while outbound data is still held.

// File: rtl/xfer_split_buf_pkg.sv
`timescale 1ns/1ps
package xfer_split_buf_pkg;
  localparam int XSB_DEPTH    = 128;
  localparam int XSB_WIDTH    = 32;
  localparam int XSB_DEF_PART = 64;
  localparam int XSB_BYTES_PER_WORD_LOG2 = 2;
endpackage

// File: rtl/xsb_ram.sv
`timescale 1ns/1ps
module xsb_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 32,
  parameter int AW    = 7
) (
  input  logic             clk,
  input  logic             a_we,
  input  logic [AW-1:0]    a_wa,
  input  logic [WIDTH-1:0] a_wd,
  input  logic             a_re,
  input  logic [AW-1:0]    a_ra,
  output logic [WIDTH-1:0] a_q,
  input  logic             b_we,
  input  logic [AW-1:0]    b_wa,
  input  logic [WIDTH-1:0] b_wd,
  input  logic             b_re,
  input  logic [AW-1:0]    b_ra,
  output logic [WIDTH-1:0] b_q
);
  logic [WIDTH-1:0] mem [DEPTH];

  // the two regions never share an address, so the write ports never collide
  always_ff @(posedge clk) begin
    if (a_we) mem[a_wa] <= a_wd;
    if (b_we) mem[b_wa] <= b_wd;
    if (a_re) a_q <= mem[a_ra];
    if (b_re) b_q <= mem[b_ra];
  end
endmodule

// File: rtl/xsb_rd_side.sv
`timescale 1ns/1ps
module xsb_rd_side #(
  parameter int WIDTH = 32,
  parameter int AW    = 7,
  parameter int LW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LW-1:0]    part,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] ram_q,
  output logic             ram_we,
  output logic [AW-1:0]    ram_wa,
  output logic             ram_re,
  output logic [AW-1:0]    ram_ra,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid,
  output logic [LW-1:0]    level,
  output logic             ovf
);
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;
  logic          pend;
  logic          push_ok, pop_ok, fetch;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [LW-1:0] lim);
    return ((LW'(p) + LW'(1)) == lim) ? '0 : p + AW'(1);
  endfunction

  assign push_ok = push && (cnt < part);
  assign pop_ok  = pop && out_valid;
  // prefetch into the output register when it is free, or frees this cycle
  assign fetch   = (cnt != '0) && !pend && (!out_valid || pop);

  assign ram_we = push_ok;
  assign ram_wa = wptr;
  assign ram_re = fetch;
  assign ram_ra = rptr;
  assign level  = cnt + LW'(pend) + LW'(out_valid);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      pend      <= 1'b0;
      out_valid <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (push_ok) wptr <= step(wptr, part);
      if (fetch)   rptr <= step(rptr, part);
      cnt  <= cnt + LW'(push_ok) - LW'(fetch);
      pend <= fetch;
      if (pend)        out_valid <= 1'b1;
      else if (pop_ok) out_valid <= 1'b0;
      ovf  <= push && !push_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (pend) out_data <= ram_q;
  end
endmodule

// File: rtl/xsb_wr_side.sv
`timescale 1ns/1ps
module xsb_wr_side #(
  parameter int DEPTH    = 128,
  parameter int WIDTH    = 32,
  parameter int AW       = 7,
  parameter int LW       = AW + 1,
  parameter int DEF_PART = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LW-1:0]    part,
  input  logic [LW-1:0]    new_part,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] ram_q,
  output logic             ram_we,
  output logic [AW-1:0]    ram_wa,
  output logic             ram_re,
  output logic [AW-1:0]    ram_ra,
  output logic [WIDTH-1:0] pop_data,
  output logic             pop_ack,
  output logic [LW-1:0]    level
);
  localparam logic [LW-1:0] TOP_ADDR = LW'(DEPTH - 1);
  localparam logic [AW-1:0] BASE0    = AW'(DEF_PART);

  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt, cap;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [LW-1:0] base);
    return (LW'(p) == TOP_ADDR) ? base[AW-1:0] : p + AW'(1);
  endfunction

  assign cap     = LW'(DEPTH) - part;
  assign push_ok = push && (cnt < cap);
  assign pop_ok  = pop && (cnt != '0);

  assign ram_we   = push_ok;
  assign ram_wa   = wptr;
  assign ram_re   = pop_ok;
  assign ram_ra   = rptr;
  assign pop_data = ram_q;
  assign level    = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= BASE0;
      rptr    <= BASE0;
      cnt     <= '0;
      pop_ack <= 1'b0;
    end else if (load) begin
      wptr    <= new_part[AW-1:0];
      rptr    <= new_part[AW-1:0];
      cnt     <= '0;
      pop_ack <= 1'b0;
    end else begin
      if (push_ok) wptr <= step(wptr, part);
      if (pop_ok)  rptr <= step(rptr, part);
      cnt     <= cnt + LW'(push_ok) - LW'(pop_ok);
      pop_ack <= pop_ok;
    end
  end
endmodule

// File: rtl/xfer_split_buf.sv
`timescale 1ns/1ps
module xfer_split_buf
  import xfer_split_buf_pkg::*;
#(
  parameter int DEPTH    = XSB_DEPTH,
  parameter int WIDTH    = XSB_WIDTH,
  parameter int DEF_PART = XSB_DEF_PART,
  localparam int AW      = $clog2(DEPTH),
  localparam int LW      = AW + 1,
  localparam int WMW     = AW + 1 + XSB_BYTES_PER_WORD_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             part_load,
  input  logic [LW-1:0]    part_val,
  input  logic             rd_push,
  input  logic [WIDTH-1:0] rd_push_data,
  input  logic             rd_pop,
  output logic [WIDTH-1:0] rd_pop_data,
  output logic             rd_pop_valid,
  output logic [LW-1:0]    rd_level,
  output logic             rd_full_hit,
  input  logic [WMW-1:0]   rd_wmark,
  output logic             rd_wm_flag,
  input  logic             wr_push,
  input  logic [WIDTH-1:0] wr_push_data,
  input  logic             wr_pop,
  output logic [WIDTH-1:0] wr_pop_data,
  output logic             wr_pop_ack,
  output logic [LW-1:0]    wr_level,
  input  logic [WMW-1:0]   wr_wmark,
  output logic             wr_wm_flag
);
  logic [LW-1:0]    part_r;
  logic             part_ok;
  logic             a_we, a_re, b_we, b_re;
  logic [AW-1:0]    a_wa, a_ra, b_wa, b_ra;
  logic [WIDTH-1:0] a_q, b_q;

  assign part_ok = part_load && (rd_level == '0) && (wr_level == '0)
                 && !rd_push && !wr_push && (part_val <= LW'(DEPTH));

  xsb_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_ram (
    .clk(clk),
    .a_we(a_we), .a_wa(a_wa), .a_wd(rd_push_data), .a_re(a_re), .a_ra(a_ra), .a_q(a_q),
    .b_we(b_we), .b_wa(b_wa), .b_wd(wr_push_data), .b_re(b_re), .b_ra(b_ra), .b_q(b_q)
  );

  xsb_rd_side #(.WIDTH(WIDTH), .AW(AW), .LW(LW)) u_rd (
    .clk(clk), .rst(rst), .load(part_ok), .part(part_r),
    .push(rd_push), .pop(rd_pop), .ram_q(a_q),
    .ram_we(a_we), .ram_wa(a_wa), .ram_re(a_re), .ram_ra(a_ra),
    .out_data(rd_pop_data), .out_valid(rd_pop_valid), .level(rd_level), .ovf(rd_full_hit)
  );

  xsb_wr_side #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .LW(LW), .DEF_PART(DEF_PART)) u_wr (
    .clk(clk), .rst(rst), .load(part_ok), .part(part_r), .new_part(part_val),
    .push(wr_push), .pop(wr_pop), .ram_q(b_q),
    .ram_we(b_we), .ram_wa(b_wa), .ram_re(b_re), .ram_ra(b_ra),
    .pop_data(wr_pop_data), .pop_ack(wr_pop_ack), .level(wr_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      part_r     <= LW'(DEF_PART);
      rd_wm_flag <= 1'b0;
      wr_wm_flag <= 1'b0;
    end else begin
      if (part_ok) part_r <= part_val;
      rd_wm_flag <= (rd_wmark != '0) && ({rd_level, 2'b00} > rd_wmark);
      wr_wm_flag <= (wr_wmark != '1) && ({wr_level, 2'b00} < wr_wmark);
    end
  end
endmodule

// File: rtl/xfer_split_buf_chk.sv
`timescale 1ns/1ps
module xfer_split_buf_chk #(
  parameter int DEPTH = 128,
  parameter int LW    = 8,
  parameter int WMW   = 10
) (
  input logic           clk,
  input logic           rst,
  input logic [LW-1:0]  part_r,
  input logic [LW-1:0]  rd_level,
  input logic [LW-1:0]  wr_level,
  input logic           rd_pop_valid,
  input logic           rd_full_hit,
  input logic           rd_push,
  input logic           wr_pop,
  input logic           wr_pop_ack,
  input logic [WMW-1:0] rd_wmark,
  input logic [WMW-1:0] wr_wmark,
  input logic           rd_wm_flag,
  input logic           wr_wm_flag
);
  // R4
  a_r4_rd_cap: assert property (@(posedge clk) disable iff (rst)
    rd_level <= part_r + LW'(1));
  // R8
  a_r8_wr_cap: assert property (@(posedge clk) disable iff (rst)
    wr_level <= LW'(DEPTH) - part_r);
  // R3
  a_r3_valid_has_data: assert property (@(posedge clk) disable iff (rst)
    rd_pop_valid |-> (rd_level != '0));
  // R5
  a_r5_hit_after_push: assert property (@(posedge clk) disable iff (rst)
    rd_full_hit |-> $past(rd_push));
  // R9
  a_r9_ack_needs_data: assert property (@(posedge clk) disable iff (rst)
    wr_pop_ack |-> ($past(wr_pop) && ($past(wr_level) != '0)));
  // R10
  a_r10_part_hold: assert property (@(posedge clk) disable iff (rst)
    ((rd_level != '0) || (wr_level != '0)) |=> $stable(part_r));
  // R11
  a_r11_rd_wm_off: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_wmark) == '0) |-> !rd_wm_flag);
  // R12
  a_r12_wr_wm_off: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_wmark) == '1) |-> !wr_wm_flag);
endmodule

bind xfer_split_buf xfer_split_buf_chk #(.DEPTH(DEPTH), .LW(LW), .WMW(WMW)) u_chk (
  .clk(clk), .rst(rst), .part_r(part_r), .rd_level(rd_level), .wr_level(wr_level),
  .rd_pop_valid(rd_pop_valid), .rd_full_hit(rd_full_hit), .rd_push(rd_push),
  .wr_pop(wr_pop), .wr_pop_ack(wr_pop_ack), .rd_wmark(rd_wmark), .wr_wmark(wr_wmark),
  .rd_wm_flag(rd_wm_flag), .wr_wm_flag(wr_wm_flag)
);

// File: tb/sim_xfer_split_buf.sv
`timescale 1ns/1ps
module sim_xfer_split_buf;
  localparam int DEPTH = 128;
  localparam int WIDTH = 32;
  localparam int LW    = 8;
  localparam int WMW   = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             part_load = 1'b0;
  logic [LW-1:0]    part_val = '0;
  logic             rd_push = 1'b0;
  logic [WIDTH-1:0] rd_push_data = '0;
  logic             rd_pop = 1'b0;
  logic [WIDTH-1:0] rd_pop_data;
  logic             rd_pop_valid;
  logic [LW-1:0]    rd_level;
  logic             rd_full_hit;
  logic [WMW-1:0]   rd_wmark = '0;
  logic             rd_wm_flag;
  logic             wr_push = 1'b0;
  logic [WIDTH-1:0] wr_push_data = '0;
  logic             wr_pop = 1'b0;
  logic [WIDTH-1:0] wr_pop_data;
  logic             wr_pop_ack;
  logic [LW-1:0]    wr_level;
  logic [WMW-1:0]   wr_wmark = '1;
  logic             wr_wm_flag;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  xfer_split_buf u0 (
    .clk(clk), .rst(rst), .part_load(part_load), .part_val(part_val),
    .rd_push(rd_push), .rd_push_data(rd_push_data), .rd_pop(rd_pop),
    .rd_pop_data(rd_pop_data), .rd_pop_valid(rd_pop_valid), .rd_level(rd_level),
    .rd_full_hit(rd_full_hit), .rd_wmark(rd_wmark), .rd_wm_flag(rd_wm_flag),
    .wr_push(wr_push), .wr_push_data(wr_push_data), .wr_pop(wr_pop),
    .wr_pop_data(wr_pop_data), .wr_pop_ack(wr_pop_ack), .wr_level(wr_level),
    .wr_wmark(wr_wmark), .wr_wm_flag(wr_wm_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_push_n(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      rd_push = 1'b1; rd_push_data = base + i;
      @(negedge clk);
    end
    rd_push = 1'b0;
  endtask

  task automatic wr_push_n(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      wr_push = 1'b1; wr_push_data = base + i;
      @(negedge clk);
    end
    wr_push = 1'b0;
  endtask

  // pops n inbound words and returns the number that were late or out of order
  task automatic rd_pop_n(input int n, input logic [31:0] base, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      for (int w = 0; w < 8 && !rd_pop_valid; w++) @(negedge clk);
      if (!rd_pop_valid || rd_pop_data != base + i) bad++;
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
  endtask

  task automatic wr_pop_n(input int n, input logic [31:0] base, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      wr_pop = 1'b1;
      @(negedge clk);
      wr_pop = 1'b0;
      if (!wr_pop_ack || wr_pop_data != base + i) bad++;
    end
  endtask

  task automatic load_part(input int p);
    part_val = LW'(p); part_load = 1'b1;
    @(negedge clk);
    part_load = 1'b0;
  endtask

  task automatic t_reset();
    chk(rd_level == 0, "R1 rd_level", 32'(rd_level), 0);
    chk(wr_level == 0, "R1 wr_level", 32'(wr_level), 0);
    chk(!rd_pop_valid && !wr_pop_ack && !rd_full_hit && !rd_wm_flag, "R1 outputs low",
        {rd_pop_valid, wr_pop_ack, rd_full_hit, rd_wm_flag}, 0);
  endtask

  task automatic t_rd_basic();
    int bad;
    rd_pop = 1'b1;                         // R3: pop while not ready
    @(negedge clk);
    rd_pop = 1'b0;
    chk(rd_level == 0 && !rd_pop_valid, "R3 empty pop ignored", 32'(rd_level), 0);
    rd_push_n(3, 32'hA000_0000);
    chk(rd_level == 3, "R2 level after pushes", 32'(rd_level), 3);
    rd_pop_n(3, 32'hA000_0000, bad);
    chk(bad == 0, "R2 order", 32'(bad), 0);
    chk(rd_level == 0, "R2 drained", 32'(rd_level), 0);
  endtask

  task automatic t_wr_basic();
    int bad;
    wr_push_n(3, 32'hB000_0000);
    chk(wr_level == 3, "R7 level", 32'(wr_level), 3);
    wr_pop_n(3, 32'hB000_0000, bad);
    chk(bad == 0, "R7 order and ack", 32'(bad), 0);
    wr_pop = 1'b1;
    @(negedge clk);
    wr_pop = 1'b0;
    chk(!wr_pop_ack && wr_level == 0, "R9 empty pop", {wr_pop_ack, 24'(wr_level)}, 0);
  endtask

  task automatic t_rd_full();
    int bad;
    load_part(4);                          // R10: accepted, regions empty
    rd_push_n(6, 32'hC000_0000);
    chk(rd_full_hit == 1'b1, "R5 drop pulse", 32'(rd_full_hit), 1);
    chk(rd_level == 5, "R4 capacity part+1", 32'(rd_level), 5);
    @(negedge clk);
    chk(rd_full_hit == 1'b0, "R5 pulse one cycle", 32'(rd_full_hit), 0);
    rd_pop_n(5, 32'hC000_0000, bad);
    chk(bad == 0, "R5 stored data intact", 32'(bad), 0);
    for (int r = 0; r < 3; r++) begin
      rd_push_n(5, 32'hC100_0000 + 32'(r * 16));
      rd_pop_n(5, 32'hC100_0000 + 32'(r * 16), bad);
      chk(bad == 0, "R6 inbound wrap order", 32'(bad), 0);
    end
  endtask

  task automatic t_wr_full();
    int bad;
    wr_push_n(126, 32'hD000_0000);
    chk(wr_level == 124, "R8 capacity depth-part", 32'(wr_level), 124);
    wr_pop_n(124, 32'hD000_0000, bad);
    chk(bad == 0, "R8 order, extras dropped", 32'(bad), 0);
    wr_push_n(3, 32'hD100_0000);
    wr_pop_n(3, 32'hD100_0000, bad);
    chk(bad == 0, "R6 outbound wrap order", 32'(bad), 0);
  endtask

  task automatic t_part_busy();
    int bad;
    wr_push_n(1, 32'hE000_0000);
    load_part(100);                        // R10: refused, outbound not empty
    wr_pop_n(1, 32'hE000_0000, bad);
    chk(bad == 0, "R10 data kept", 32'(bad), 0);
    rd_push_n(7, 32'hE100_0000);
    chk(rd_level == 5, "R10 partition unchanged", 32'(rd_level), 5);
    rd_pop_n(5, 32'hE100_0000, bad);
    chk(bad == 0, "R10 inbound order", 32'(bad), 0);
  endtask

  task automatic t_wmarks();
    int bad;
    rd_wmark = 10'd8;
    rd_push_n(1, 32'hF000_0000);
    @(negedge clk);
    chk(!rd_wm_flag, "R11 4B not above 8B", 32'(rd_wm_flag), 0);
    rd_push_n(1, 32'hF000_0001);
    @(negedge clk);
    chk(!rd_wm_flag, "R11 8B not above 8B", 32'(rd_wm_flag), 0);
    rd_push_n(1, 32'hF000_0002);
    @(negedge clk);
    chk(rd_wm_flag, "R11 12B above 8B", 32'(rd_wm_flag), 1);
    rd_wmark = '0;
    @(negedge clk); @(negedge clk);
    chk(!rd_wm_flag, "R11 zero disables", 32'(rd_wm_flag), 0);
    rd_pop_n(3, 32'hF000_0000, bad);
    chk(bad == 0, "R11 data", 32'(bad), 0);

    wr_wmark = 10'd12;
    @(negedge clk); @(negedge clk);
    chk(wr_wm_flag, "R12 empty below 12B", 32'(wr_wm_flag), 1);
    wr_push_n(2, 32'hF100_0000);
    @(negedge clk);
    chk(wr_wm_flag, "R12 8B below 12B", 32'(wr_wm_flag), 1);
    wr_push_n(1, 32'hF100_0002);
    @(negedge clk);
    chk(!wr_wm_flag, "R12 12B not below", 32'(wr_wm_flag), 0);
    wr_wmark = '1;
    wr_pop_n(3, 32'hF100_0000, bad);
    @(negedge clk);
    chk(!wr_wm_flag && bad == 0, "R12 all-ones disables", {wr_wm_flag, 24'(bad)}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1-scope run hung actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rd_basic();
    t_wr_basic();
    t_rd_full();
    t_wr_full();
    t_part_busy();
    t_wmarks();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule